// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital control engine for a 12-bit successive-approximation converter that serves up to 18 input channels. It runs two programmable lists of channels. The regular list has up to 16 slots. The injected list has up to 4 slots, and an injected request takes precedence over the regular list. For each conversion the block places a channel number on a select bus and pulses a start strobe. It then counts out the sample phase and the conversion phase. When the conversion phase ends, it captures the 12-bit code from the converter core into a result register.

The block runs on a clock at twice the converter clock rate, so one clock is one half converter cycle. Sample times of the form n.5 cycles and the fixed conversion phase of 12.5 cycles are therefore counted exactly. An injected trigger that arrives during a regular scan waits for the running regular conversion to finish. The whole injected list then runs, and the regular scan continues at the slot after the one it stopped on. Regular results all go to one register, and each new result replaces the previous one. Injected results go to one register per injected slot.

Top module: `conv_sequencer`

## Requirements
- R1: While `rst_n` is low and after it is released with no trigger, `core_start`, `core_sampling`, `reg_eoc`, `inj_eoc`, `reg_data` and all of `inj_data` are zero.
- R2: A conversion lasts exactly H+25 clocks, from the cycle in which `core_start` is high to the cycle in which its end flag is high. H is the half-cycle count of the channel's 3-bit sample code: codes 0..7 give 3, 15, 27, 57, 83, 111, 143 and 479. The code of channel c is `cfg_smp_codes[3c+2:3c]`. `core_start` is high for a single cycle.
- R3: With `cfg_scan` low and `cfg_cont` low, a regular trigger converts only regular slot 0 (`cfg_reg_slots[4:0]`), once, and then the block goes idle.
- R4: With `cfg_scan` high, a regular trigger converts slots 0 to `cfg_reg_len` in ascending order. Slot k is `cfg_reg_slots[5k+4:5k]`, and the length field holds the count minus one. Each following `core_start` falls in the same cycle as the previous `reg_eoc`.
- R5: With `cfg_cont` high, the regular sequence starts again from slot 0 after its last slot. Clearing `cfg_cont` stops the block at the end of the sequence that is running.
- R6: An injected run converts injected slots 3−`cfg_inj_len` up to 3 in ascending order. Slot k is `cfg_inj_slots[5k+4:5k]`. A length of 0 converts only slot 3, and a length of 3 converts slots 0 to 3.
- R7: If an injected trigger arrives during a regular conversion, the first injected `core_start` falls in the cycle of that conversion's `reg_eoc`. After the last injected slot, the regular scan resumes at its next slot.
- R8: Every regular result overwrites `reg_data`. An injected result for slot k goes to `inj_data[16k+15:16k]`, and the other injected registers keep their values.
- R9: With `cfg_left` low a result is stored as {4'b0, code}. With it high the result is stored as {code, 4'b0}.
- R10: `reg_eoc` is high for one cycle after each regular result, in the cycle the new `reg_data` is first visible. `inj_eoc` is high for one cycle only after injected slot 3 completes.
- R11: A trigger that arrives while its group is busy is held, and its sequence starts when the running one ends. Further triggers of that group before that start are dropped.
- R12: `core_chan` holds the channel of the running conversion from its `core_start` until its end. `core_data` is sampled on the final clock of the conversion phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reg_slots | input | 80 | Regular slot channels, 5 bits per slot, slot 0 in the low bits |
| cfg_reg_len | input | 4 | Regular conversion count minus one |
| cfg_inj_slots | input | 20 | Injected slot channels, 5 bits per slot |
| cfg_inj_len | input | 2 | Injected conversion count minus one |
| cfg_smp_codes | input | 54 | Sample-time code per channel, 3 bits each |
| cfg_scan | input | 1 | Step through all regular slots |
| cfg_cont | input | 1 | Restart the regular sequence after its end |
| cfg_left | input | 1 | Left-align results |
| reg_trig | input | 1 | Regular start request, one-cycle pulse |
| inj_trig | input | 1 | Injected start request, one-cycle pulse |
| core_chan | output | 5 | Channel select to the converter core |
| core_start | output | 1 | Start strobe to the converter core |
| core_sampling | output | 1 | High during the sample phase |
| core_data | input | 12 | Code from the converter core |
| reg_data | output | 16 | Shared regular result |
| reg_eoc | output | 1 | Regular result written |
| inj_data | output | 64 | Four injected results, 16 bits each |
| inj_eoc | output | 1 | Injected run finished |

## Verification
The embedded properties check the following on every clock:
- the start strobe and the regular end flag are single-cycle pulses;
- a conversion is only launched once the previous one has ended;
- a held regular request is either kept or turned into a regular start;
- an injected request pending at a regular boundary is always served next;
- an injected write leaves the other injected registers unchanged;
- the injected end flag appears only after slot 3.

Exact durations for each sample code, slot order in scan and injected runs, resumption after preemption, continuous restart and its stop, alignment, and the dropping of a surplus trigger can only be shown by the directed scenarios. Those scenarios use a core model whose code depends on the selected channel.

// File: rtl/conv_seq_pkg.sv
// Shared constants, types and the sample-time lookup for the conversion
// sequencer. Time is counted in half converter cycles.
package conv_seq_pkg;

    localparam int RES_W     = 12;   // converter code width
    localparam int OUT_W     = 16;   // result field width
    localparam int CH_W      = 5;    // channel number width
    localparam int SMP_W     = 3;    // sample-time code width
    localparam int HALF_W    = 9;    // width of a half-cycle count
    localparam int CONV_HALF = 25;   // 12.5 converter cycles

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_INJ    = 2'd1,
        PICK_REG_GO = 2'd2,
        PICK_REG_NW = 2'd3
    } pick_e;

    // Half-cycle count of each sample code (n.5 cycles -> 2n+1 halves).
    function automatic logic [HALF_W-1:0] smp_half(input logic [SMP_W-1:0] code);
        logic [HALF_W-1:0] h;
        case (code)
            3'd0:    h = HALF_W'(3);
            3'd1:    h = HALF_W'(15);
            3'd2:    h = HALF_W'(27);
            3'd3:    h = HALF_W'(57);
            3'd4:    h = HALF_W'(83);
            3'd5:    h = HALF_W'(111);
            3'd6:    h = HALF_W'(143);
            default: h = HALF_W'(479);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/conv_slot_pick.sv
// Selects the channel number held in one slot of a packed slot list.
// Assumes idx is below SLOTS; purely combinational.
module conv_slot_pick #(
    parameter int SLOTS = 16,
    parameter int CH_W  = 5,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS*CH_W-1:0] slots,
    input  logic [IDX_W-1:0]      idx,
    output logic [CH_W-1:0]       chan
);

    logic [CH_W-1:0] tbl [SLOTS];

    // Unpack the slot list into an indexable table.
    for (genvar g = 0; g < SLOTS; g++) begin : g_unpack
        assign tbl[g] = slots[g*CH_W +: CH_W];
    end

    assign chan = tbl[idx];

endmodule

// File: rtl/conv_phase_timer.sv
// Counts the sample phase (a per-conversion half-cycle count) and then the
// fixed conversion phase. 'done' is high in the last conversion clock.
// Assumes launch is only raised when idle or in the done cycle.
module conv_phase_timer
    import conv_seq_pkg::*;
#(
    parameter int CNT_W   = HALF_W,
    parameter int CONV_CT = CONV_HALF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CNT_W-1:0] smp_half_in,
    output logic             sampling,
    output logic             converting,
    output logic             done
);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    assign sampling   = (phase == PH_SAMP);
    assign converting = (phase == PH_CONV);
    assign done       = converting && (cnt == '0);

    // Phase and down-counter; a launch always wins and reloads the sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (launch) begin
            phase <= PH_SAMP;
            cnt   <= smp_half_in - 1'b1;
        end else begin
            case (phase)
                PH_SAMP: begin
                    if (cnt == '0) begin
                        phase <= PH_CONV;
                        cnt   <= CNT_W'(CONV_CT - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_LAUNCH_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (phase == PH_IDLE || done)); // R2

endmodule

// File: rtl/conv_result_bank.sv
// Holds the shared regular result and one register per injected slot,
// applies alignment on write and raises the end-of-conversion pulses.
// Assumes at most one write per cycle.
module conv_result_bank #(
    parameter int RES_W = 12,
    parameter int OUT_W = 16,
    parameter int SLOTS = 4,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int PAD_W = OUT_W - RES_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_reg,
    input  logic                   wr_inj,
    input  logic [IDX_W-1:0]       wr_slot,
    input  logic [RES_W-1:0]       wr_code,
    input  logic                   left,
    output logic [OUT_W-1:0]       reg_data,
    output logic                   reg_eoc,
    output logic [SLOTS*OUT_W-1:0] inj_data,
    output logic                   inj_eoc
);

    logic [OUT_W-1:0] aligned;
    logic [OUT_W-1:0] inj_q [SLOTS];

    assign aligned = left ? {wr_code, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, wr_code};

    // Shared regular result and the two end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_data <= '0;
            reg_eoc  <= 1'b0;
            inj_eoc  <= 1'b0;
        end else begin
            if (wr_reg) reg_data <= aligned;
            reg_eoc <= wr_reg;
            inj_eoc <= wr_inj && (wr_slot == IDX_W'(SLOTS - 1));
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_inj
        // Per-slot injected result register.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    inj_q[g] <= '0;
            else if (wr_inj && (wr_slot == IDX_W'(g)))     inj_q[g] <= aligned;
        end
        assign inj_data[g*OUT_W +: OUT_W] = inj_q[g];

        AST_OTHER_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_inj && wr_slot != IDX_W'(g)) |=> $stable(inj_data[g*OUT_W +: OUT_W])); // R8
    end

    AST_REG_EOC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_eoc |=> !reg_eoc); // R10

endmodule

// File: rtl/conv_sequencer.sv
// Top of the conversion sequencer. Arbitrates between the regular and the
// injected list at conversion boundaries, drives the converter core and
// routes results. Assumes configuration inputs are held stable while a
// sequence runs and that clk runs at twice the converter clock.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int N_CH      = 18,
    parameter int REG_SLOTS = 16,
    parameter int INJ_SLOTS = 4,
    localparam int REG_IDX_W = $clog2(REG_SLOTS),
    localparam int INJ_IDX_W = $clog2(INJ_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [REG_SLOTS*CH_W-1:0]  cfg_reg_slots,
    input  logic [REG_IDX_W-1:0]       cfg_reg_len,
    input  logic [INJ_SLOTS*CH_W-1:0]  cfg_inj_slots,
    input  logic [INJ_IDX_W-1:0]       cfg_inj_len,
    input  logic [N_CH*SMP_W-1:0]      cfg_smp_codes,
    input  logic                       cfg_scan,
    input  logic                       cfg_cont,
    input  logic                       cfg_left,
    input  logic                       reg_trig,
    input  logic                       inj_trig,
    output logic [CH_W-1:0]            core_chan,
    output logic                       core_start,
    output logic                       core_sampling,
    input  logic [RES_W-1:0]           core_data,
    output logic [OUT_W-1:0]           reg_data,
    output logic                       reg_eoc,
    output logic [INJ_SLOTS*OUT_W-1:0] inj_data,
    output logic                       inj_eoc
);

    logic                 converting, done, free, launch, launch_inj;
    logic                 cur_inj, reg_active, reg_pend, inj_pend;
    logic [REG_IDX_W-1:0] cur_idx, reg_next;
    logic                 reg_act_nx, reg_last, inj_more, inj_take;
    logic [REG_IDX_W-1:0] reg_next_nx, reg_idx_nx;
    logic [INJ_IDX_W-1:0] inj_idx_nx;
    logic [CH_W-1:0]      reg_chan, inj_chan, nxt_chan;
    logic [SMP_W-1:0]     nxt_code;
    logic                 inj_go, reg_go;
    pick_e                pick;

    assign free     = (!core_sampling && !converting) || done;
    assign inj_go   = inj_pend || inj_trig;
    assign reg_go   = reg_pend || reg_trig;
    assign inj_more = done && cur_inj &&
                      (cur_idx[INJ_IDX_W-1:0] != INJ_IDX_W'(INJ_SLOTS - 1));
    assign reg_last = !cfg_scan || (cur_idx == cfg_reg_len);

    // Regular progress after the conversion that may be ending now.
    always_comb begin
        reg_act_nx  = reg_active;
        reg_next_nx = reg_next;
        if (done && !cur_inj) begin
            reg_act_nx  = reg_last ? cfg_cont : 1'b1;
            reg_next_nx = reg_last ? '0 : cur_idx + 1'b1;
        end
    end

    // Boundary arbitration: running injected run, new injected run, regular.
    always_comb begin
        pick       = PICK_NONE;
        inj_idx_nx = cur_idx[INJ_IDX_W-1:0] + 1'b1;
        if (free) begin
            if (inj_more) begin
                pick = PICK_INJ;
            end else if (inj_go) begin
                pick       = PICK_INJ;
                inj_idx_nx = INJ_IDX_W'(INJ_SLOTS - 1) - cfg_inj_len;
            end else if (reg_act_nx) begin
                pick = PICK_REG_GO;
            end else if (reg_go) begin
                pick = PICK_REG_NW;
            end
        end
    end

    assign launch     = (pick != PICK_NONE);
    assign launch_inj = (pick == PICK_INJ);
    assign inj_take   = free && !inj_more && inj_go;
    assign reg_idx_nx = (pick == PICK_REG_NW) ? '0 : reg_next_nx;

    conv_slot_pick #(.SLOTS(REG_SLOTS), .CH_W(CH_W)) i_reg_pick (
        .slots(cfg_reg_slots), .idx(reg_idx_nx), .chan(reg_chan));

    conv_slot_pick #(.SLOTS(INJ_SLOTS), .CH_W(CH_W)) i_inj_pick (
        .slots(cfg_inj_slots), .idx(inj_idx_nx), .chan(inj_chan));

    assign nxt_chan = launch_inj ? inj_chan : reg_chan;

    // Sample code of the chosen channel; out-of-range channels use code 0.
    always_comb begin
        nxt_code = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (nxt_chan == CH_W'(c)) nxt_code = cfg_smp_codes[c*SMP_W +: SMP_W];
        end
    end

    conv_phase_timer #(.CNT_W(HALF_W), .CONV_CT(CONV_HALF)) i_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .smp_half_in(smp_half(nxt_code)),
        .sampling(core_sampling), .converting(converting), .done(done));

    // Sequencing state, pending requests and the core-side strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_start <= 1'b0;
            core_chan  <= '0;
            cur_inj    <= 1'b0;
            cur_idx    <= '0;
            reg_active <= 1'b0;
            reg_next   <= '0;
            inj_pend   <= 1'b0;
            reg_pend   <= 1'b0;
        end else begin
            core_start <= launch;
            if (launch) begin
                core_chan <= nxt_chan;
                cur_inj   <= launch_inj;
                cur_idx   <= launch_inj ? REG_IDX_W'(inj_idx_nx) : reg_idx_nx;
            end
            reg_active <= (pick == PICK_REG_NW) ? 1'b1 : reg_act_nx;
            reg_next   <= reg_next_nx;
            inj_pend   <= inj_take ? 1'b0 : inj_go;
            reg_pend   <= (pick == PICK_REG_NW) ? 1'b0 : reg_go;
        end
    end

    conv_result_bank #(.RES_W(RES_W), .OUT_W(OUT_W), .SLOTS(INJ_SLOTS)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_reg(done && !cur_inj), .wr_inj(done && cur_inj),
        .wr_slot(cur_idx[INJ_IDX_W-1:0]), .wr_code(core_data), .left(cfg_left),
        .reg_data(reg_data), .reg_eoc(reg_eoc), .inj_data(inj_data), .inj_eoc(inj_eoc));

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R2

    AST_PREEMPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cur_inj && inj_pend) |=> (core_start && cur_inj)); // R7

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        reg_pend |=> (reg_pend || (core_start && !cur_inj))); // R11

    AST_INJ_EOC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        inj_eoc |-> $past(cur_inj && cur_idx == REG_IDX_W'(INJ_SLOTS - 1))); // R10

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (converting && !done) |=> $stable(core_chan)); // R12

endmodule

// File: tb/test_conv_sequencer.sv
// Directed bench for conv_sequencer: one task per scenario.
module test_conv_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [79:0] cfg_reg_slots = '0;
    logic [3:0]  cfg_reg_len = '0;
    logic [19:0] cfg_inj_slots = '0;
    logic [1:0]  cfg_inj_len = '0;
    logic [53:0] cfg_smp_codes = '0;
    logic        cfg_scan = 1'b0, cfg_cont = 1'b0, cfg_left = 1'b0;
    logic        reg_trig = 1'b0, inj_trig = 1'b0;
    logic [4:0]  core_chan;
    logic        core_start, core_sampling;
    logic [11:0] core_data;
    logic [15:0] reg_data;
    logic        reg_eoc, inj_eoc;
    logic [63:0] inj_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_st = 0, n_eoc = 0, n_ieoc = 0;
    int st_chan [64];
    int st_cyc  [64];
    int eoc_cyc [64];
    int eoc_dat [64];
    bit finished = 1'b0;
    localparam int HALF_TBL [8] = '{3, 15, 27, 57, 83, 111, 143, 479};

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [11:0] model_val(input logic [4:0] ch);
        return 12'(int'(ch) * 97 + 301);
    endfunction

    assign core_data = model_val(core_chan);

    conv_sequencer i_conv_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_reg_slots(cfg_reg_slots), .cfg_reg_len(cfg_reg_len),
        .cfg_inj_slots(cfg_inj_slots), .cfg_inj_len(cfg_inj_len),
        .cfg_smp_codes(cfg_smp_codes), .cfg_scan(cfg_scan), .cfg_cont(cfg_cont),
        .cfg_left(cfg_left), .reg_trig(reg_trig), .inj_trig(inj_trig),
        .core_chan(core_chan), .core_start(core_start), .core_sampling(core_sampling),
        .core_data(core_data), .reg_data(reg_data), .reg_eoc(reg_eoc),
        .inj_data(inj_data), .inj_eoc(inj_eoc));

    always @(posedge clk) cyc <= cyc + 1;

    // Event log sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && core_start && n_st < 64) begin
            st_chan[n_st] = int'(core_chan); st_cyc[n_st] = cyc; n_st = n_st + 1;
        end
        if (rst_n && reg_eoc && n_eoc < 64) begin
            eoc_cyc[n_eoc] = cyc; eoc_dat[n_eoc] = int'(reg_data); n_eoc = n_eoc + 1;
        end
        if (rst_n && inj_eoc) n_ieoc = n_ieoc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_st = 0; n_eoc = 0; n_ieoc = 0;
    endtask

    task automatic pulse_reg();
        reg_trig = 1'b1; @(negedge clk); reg_trig = 1'b0;
    endtask

    task automatic pulse_inj();
        inj_trig = 1'b1; @(negedge clk); inj_trig = 1'b0;
    endtask

    task automatic set_code(input int ch, input int code);
        cfg_smp_codes[ch*3 +: 3] = 3'(code);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(core_start == 0 && core_sampling == 0, "R1 strobes idle", int'(core_start), 0);
        check(reg_data == 0 && inj_data == 0, "R1 results zero", int'(reg_data), 0);
        check(reg_eoc == 0 && inj_eoc == 0, "R1 flags low", int'(reg_eoc), 0);
    endtask

    task automatic t_single();
        clear_log();
        cfg_scan = 0; cfg_cont = 0; cfg_left = 0;
        cfg_reg_slots[0 +: 5] = 5'd5; cfg_reg_slots[5 +: 5] = 5'd6; cfg_reg_len = 4'd1;
        set_code(5, 1);
        pulse_reg();
        repeat (300) @(negedge clk);
        check(n_st == 1, "R3 one conversion", n_st, 1);
        check(st_chan[0] == 5, "R3 slot 0 channel", st_chan[0], 5);
        check(eoc_cyc[0] - st_cyc[0] == 15 + 25, "R2 duration code 1", eoc_cyc[0] - st_cyc[0], 40);
        check(reg_data == {4'b0, model_val(5'd5)}, "R9 right aligned", int'(reg_data),
              int'(model_val(5'd5)));
    endtask

    task automatic t_table();
        cfg_scan = 0; cfg_cont = 0;
        cfg_reg_slots[0 +: 5] = 5'd0;
        for (int code = 0; code < 8; code++) begin
            clear_log();
            set_code(0, code);
            pulse_reg();
            repeat (560) @(negedge clk);
            check(n_eoc == 1 && eoc_cyc[0] - st_cyc[0] == HALF_TBL[code] + 25,
                  $sformatf("R2 duration code %0d", code),
                  eoc_cyc[0] - st_cyc[0], HALF_TBL[code] + 25);
        end
    endtask

    task automatic t_scan();
        int exp_ch [3] = '{3, 9, 17};
        clear_log();
        cfg_scan = 1; cfg_cont = 0; cfg_reg_len = 4'd2;
        cfg_reg_slots[0 +: 5] = 5'd3; cfg_reg_slots[5 +: 5] = 5'd9; cfg_reg_slots[10 +: 5] = 5'd17;
        set_code(3, 0); set_code(9, 2); set_code(17, 1);
        pulse_reg();
        repeat (300) @(negedge clk);
        check(n_st == 3 && n_eoc == 3, "R4 three conversions", n_st, 3);
        for (int k = 0; k < 3; k++) begin
            check(st_chan[k] == exp_ch[k], "R4 slot order", st_chan[k], exp_ch[k]);
            check(eoc_dat[k] == int'(model_val(5'(exp_ch[k]))), "R12 code matches channel",
                  eoc_dat[k], int'(model_val(5'(exp_ch[k]))));
        end
        check(st_cyc[1] == eoc_cyc[0] && st_cyc[2] == eoc_cyc[1], "R4 back to back",
              st_cyc[1], eoc_cyc[0]);
        check(eoc_cyc[1] - st_cyc[1] == 27 + 25, "R2 duration in scan", eoc_cyc[1] - st_cyc[1], 52);
        check(reg_data == {4'b0, model_val(5'd17)}, "R8 last result overwrites",
              int'(reg_data), int'(model_val(5'd17)));
    endtask

    task automatic t_left();
        clear_log();
        cfg_scan = 0; cfg_left = 1;
        cfg_reg_slots[0 +: 5] = 5'd9;
        pulse_reg();
        repeat (200) @(negedge clk);
        check(reg_data == {model_val(5'd9), 4'b0}, "R9 left aligned", int'(reg_data),
              int'({model_val(5'd9), 4'b0}));
        cfg_left = 0;
    endtask

    task automatic t_cont();
        int hold;
        clear_log();
        cfg_scan = 1; cfg_cont = 1; cfg_reg_len = 4'd1;
        cfg_reg_slots[0 +: 5] = 5'd3; cfg_reg_slots[5 +: 5] = 5'd9;
        pulse_reg();
        while (n_st < 5) @(negedge clk);
        cfg_cont = 0;
        repeat (300) @(negedge clk);
        check(st_chan[2] == 3 && st_chan[3] == 9 && st_chan[4] == 3, "R5 restart from slot 0",
              st_chan[2], 3);
        check(n_st == 6 && st_chan[5] == 9, "R5 stops at sequence end", n_st, 6);
        hold = n_st;
        repeat (200) @(negedge clk);
        check(n_st == hold, "R5 stays idle", n_st, hold);
    endtask

    task automatic t_inj(input int jl);
        int first = 3 - jl;
        clear_log();
        cfg_inj_slots = {5'd6, 5'd4, 5'd2, 5'd1};
        set_code(1, 0); set_code(2, 0); set_code(4, 0); set_code(6, 0);
        cfg_inj_len = 2'(jl);
        pulse_inj();
        repeat (250) @(negedge clk);
        check(n_st == jl + 1, $sformatf("R6 count len %0d", jl), n_st, jl + 1);
        for (int k = 0; k <= jl; k++) begin
            check(st_chan[k] == int'(cfg_inj_slots[(first + k)*5 +: 5]), "R6 injected order",
                  st_chan[k], int'(cfg_inj_slots[(first + k)*5 +: 5]));
        end
        for (int s = 0; s < 4; s++) begin
            int exp = (s >= first) ? int'(model_val(cfg_inj_slots[s*5 +: 5])) : 0;
            check(int'(inj_data[s*16 +: 16]) == exp, "R8 injected register", int'(inj_data[s*16 +: 16]), exp);
        end
        check(n_ieoc == 1, "R10 one injected end flag", n_ieoc, 1);
        check(n_eoc == 0, "R10 no regular flag", n_eoc, 0);
    endtask

    task automatic t_preempt();
        int exp_ch [6] = '{10, 4, 6, 11, 12, 13};
        clear_log();
        cfg_scan = 1; cfg_cont = 0; cfg_reg_len = 4'd3;
        for (int k = 0; k < 4; k++) begin
            cfg_reg_slots[k*5 +: 5] = 5'(10 + k);
            set_code(10 + k, 3);
        end
        cfg_inj_len = 2'd1;
        pulse_reg();
        repeat (10) @(negedge clk);
        pulse_inj();
        repeat (600) @(negedge clk);
        check(n_st == 6, "R7 total conversions", n_st, 6);
        for (int k = 0; k < 6; k++)
            check(st_chan[k] == exp_ch[k], "R7 preempt order", st_chan[k], exp_ch[k]);
        check(st_cyc[1] == eoc_cyc[0], "R7 injected starts at boundary", st_cyc[1], eoc_cyc[0]);
        check(n_eoc == 4 && n_ieoc == 1, "R7 flags after resume", n_eoc, 4);
    endtask

    task automatic t_latch();
        clear_log();
        cfg_scan = 1; cfg_cont = 0; cfg_reg_len = 4'd1;
        cfg_reg_slots[0 +: 5] = 5'd3; cfg_reg_slots[5 +: 5] = 5'd9;
        pulse_reg();
        repeat (5) @(negedge clk);
        pulse_reg();
        repeat (5) @(negedge clk);
        pulse_reg();
        repeat (400) @(negedge clk);
        check(n_st == 4, "R11 surplus trigger dropped", n_st, 4);
        check(st_cyc[2] == eoc_cyc[1], "R11 held trigger starts at end", st_cyc[2], eoc_cyc[1]);
        check(st_chan[2] == 3, "R11 held sequence from slot 0", st_chan[2], 3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_table();
        t_scan();
        t_left();
        t_cont();
        t_inj(0);
        t_inj(1);
        t_inj(3);
        t_preempt();
        t_latch();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule